// File: doc/BRIEF.md
# Nested Vectored Interrupt Controller

This block collects a group of level-sensitive interrupt lines and drives a single request line towards a processor. Software gives each source a handler address and a priority through a small write port. When the processor acknowledges the request, the controller hands back the handler address of the most urgent pending source. It also records that source's priority as the new service level.

Service levels sit on a hardware stack. While a handler runs, only a source whose priority is strictly above the level on top of the stack can raise a new request, so preemption can nest several levels deep. When the processor signals end-of-service, the top entry is removed and the previous level, with the sources it was masking, comes back into force.

Top module: `ivc_top`

## Requirements
- R1: After reset the request output is 0, the vector output is 0, the current level is 0 and the overflow flag is 0.
- R2: A write with address 2i stores the full data word as the vector of source i. A write with address 2i+1 stores the low 3 bits of the data word as the priority of source i. A priority of 0 disables the source, and it never causes a request.
- R3: When an enabled source is active and its priority is above the current level, the request output goes to 1 one clock after that condition appears.
- R4: On an acknowledge, the vector output takes on, from the next cycle, the vector of the pending source with the highest priority. When priorities tie, the lower source index wins.
- R5: An accepted acknowledge pushes the winner's priority, and the level output shows it from the next cycle. The request output is 0 in the cycle after any acknowledge or end-of-service, and is then recomputed.
- R6: At a given level, sources of equal or lower priority cause no request. A source of strictly higher priority causes a request and can be acknowledged on top, which nests the levels.
- R7: An end-of-service pops the stack, and the level output returns to the previous entry, or to 0 when the stack empties. Sources that were masked can then request again.
- R8: An end-of-service with an empty stack is ignored. The level stays 0 and the vector is unchanged.
- R9: An acknowledge with a full stack still latches the vector, but the level is not pushed. The overflow flag is set and stays 1 until reset.
- R10: An acknowledge when no source is eligible is ignored. The vector and the level are unchanged.
- R11: When acknowledge and end-of-service arrive in the same cycle, the end-of-service is ignored and only the acknowledge takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_i | input | 8 | Level-sensitive interrupt lines, one per source |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 4 | Configuration address (2i vector, 2i+1 priority) |
| cfg_wdata | input | 32 | Configuration write data |
| ack_i | input | 1 | Processor acknowledge |
| eos_i | input | 1 | End-of-service from the processor |
| irq_req_o | output | 1 | Interrupt request to the processor |
| vec_o | output | 32 | Vector latched on the last accepted acknowledge |
| level_o | output | 3 | Current service level (top of stack, 0 when empty) |
| overflow_o | output | 1 | Sticky flag: an acknowledge found the stack full |

## Verification
A wrong stack pointer or a wrong stored entry shows up on the level output in the cycle after the acknowledge or end-of-service that caused it. One cycle later it also shows on the request line, because that line then masks the wrong sources. A wrong winner in the arbiter shows on the vector output one cycle after the acknowledge. A lost overflow bit shows at once on the sticky flag. The bench nests levels, unwinds them again and overfills a reduced-depth stack, so each of these faults reaches the ports within two clocks.

// File: rtl/ivc_pkg.sv
package ivc_pkg;
    localparam int DEF_N_SRC   = 8;
    localparam int DEF_PRIO_W  = 3;
    localparam int DEF_VEC_W   = 32;
    localparam int DEF_STK_DEP = 8;

    typedef enum logic [1:0] {
        STK_HOLD = 2'd0,
        STK_PUSH = 2'd1,
        STK_POP  = 2'd2
    } stk_op_e;
endpackage

// File: rtl/ivc_cfg.sv
module ivc_cfg #(
    parameter int N_SRC  = 8,
    parameter int PRIO_W = 3,
    parameter int VEC_W  = 32,
    parameter int AW     = $clog2(2 * N_SRC)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           we,
    input  logic [AW-1:0]                  addr,
    input  logic [VEC_W-1:0]               wdata,
    output logic [N_SRC-1:0][VEC_W-1:0]    vec_tbl,
    output logic [N_SRC-1:0][PRIO_W-1:0]   prio_tbl
);
    localparam int IW = (N_SRC > 1) ? $clog2(N_SRC) : 1;

    typedef struct packed {
        logic [N_SRC-1:0][VEC_W-1:0]  vec;
        logic [N_SRC-1:0][PRIO_W-1:0] prio;
    } cfg_st_t;

    cfg_st_t st_d, st_q;
    logic [IW-1:0] widx;

    assign widx = IW'(addr >> 1);

    always_comb begin
        st_d = st_q;
        if (we && (32'(addr >> 1) < N_SRC)) begin
            if (addr[0]) st_d.prio[widx] = wdata[PRIO_W-1:0];
            else         st_d.vec[widx]  = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign vec_tbl  = st_q.vec;
    assign prio_tbl = st_q.prio;
endmodule

// File: rtl/ivc_arb.sv
module ivc_arb #(
    parameter int N_SRC  = 8,
    parameter int PRIO_W = 3,
    parameter int IW     = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic [N_SRC-1:0]               irq,
    input  logic [N_SRC-1:0][PRIO_W-1:0]   prio_tbl,
    input  logic [PRIO_W-1:0]              level,
    output logic                           vld,
    output logic [IW-1:0]                  idx,
    output logic [PRIO_W-1:0]              prio
);
    logic [N_SRC-1:0] elig;

    genvar g;
    generate
        for (g = 0; g < N_SRC; g++) begin : g_elig
            assign elig[g] = irq[g] && (prio_tbl[g] != '0) && (prio_tbl[g] > level);
        end
    endgenerate

    // Scan from the top index down with >=, so on a tie the lowest index is kept.
    always_comb begin
        vld  = 1'b0;
        idx  = '0;
        prio = '0;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (elig[i] && (prio_tbl[i] >= prio)) begin
                vld  = 1'b1;
                idx  = IW'(i);
                prio = prio_tbl[i];
            end
        end
    end
endmodule

// File: rtl/ivc_stack.sv
module ivc_stack
    import ivc_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int PRIO_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  stk_op_e           op,
    input  logic [PRIO_W-1:0] push_val,
    output logic [PRIO_W-1:0] top,
    output logic              full,
    output logic              empty
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [DEPTH-1:0][PRIO_W-1:0] ent;
        logic [CW-1:0]                cnt;
    } stk_st_t;

    stk_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (op)
            STK_PUSH: if (st_q.cnt != CW'(DEPTH)) begin
                st_d.ent[PW'(st_q.cnt)] = push_val;
                st_d.cnt                = st_q.cnt + 1'b1;
            end
            STK_POP: if (st_q.cnt != '0) begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign empty = (st_q.cnt == '0);
    assign full  = (st_q.cnt == CW'(DEPTH));
    assign top   = empty ? '0 : st_q.ent[PW'(st_q.cnt - 1'b1)];
endmodule

// File: rtl/ivc_top.sv
module ivc_top
    import ivc_pkg::*;
#(
    parameter int N_SRC   = DEF_N_SRC,
    parameter int PRIO_W  = DEF_PRIO_W,
    parameter int VEC_W   = DEF_VEC_W,
    parameter int STK_DEP = DEF_STK_DEP,
    localparam int AW     = $clog2(2 * N_SRC),
    localparam int IW     = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  irq_i,
    input  logic              cfg_we,
    input  logic [AW-1:0]     cfg_addr,
    input  logic [VEC_W-1:0]  cfg_wdata,
    input  logic              ack_i,
    input  logic              eos_i,
    output logic              irq_req_o,
    output logic [VEC_W-1:0]  vec_o,
    output logic [PRIO_W-1:0] level_o,
    output logic              overflow_o
);
    typedef struct packed {
        logic             req;
        logic [VEC_W-1:0] vec;
        logic             ovf;
    } top_st_t;

    top_st_t st_d, st_q;

    logic [N_SRC-1:0][VEC_W-1:0]  vec_tbl;
    logic [N_SRC-1:0][PRIO_W-1:0] prio_tbl;
    logic                         arb_vld;
    logic [IW-1:0]                arb_idx;
    logic [PRIO_W-1:0]            arb_prio;
    logic [PRIO_W-1:0]            stk_top;
    logic                         stk_full;
    logic                         stk_empty;
    stk_op_e                      stk_op;
    logic                         ack_take;

    ivc_cfg #(.N_SRC(N_SRC), .PRIO_W(PRIO_W), .VEC_W(VEC_W), .AW(AW)) u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
        .vec_tbl(vec_tbl), .prio_tbl(prio_tbl)
    );

    ivc_arb #(.N_SRC(N_SRC), .PRIO_W(PRIO_W), .IW(IW)) u_arb (
        .irq(irq_i), .prio_tbl(prio_tbl), .level(stk_top),
        .vld(arb_vld), .idx(arb_idx), .prio(arb_prio)
    );

    ivc_stack #(.DEPTH(STK_DEP), .PRIO_W(PRIO_W)) u_stk (
        .clk(clk), .rst_n(rst_n), .op(stk_op), .push_val(arb_prio),
        .top(stk_top), .full(stk_full), .empty(stk_empty)
    );

    always_comb begin
        st_d     = st_q;
        ack_take = ack_i && arb_vld;
        stk_op   = STK_HOLD;
        if (ack_take) begin
            st_d.vec = vec_tbl[arb_idx];
            if (stk_full) st_d.ovf = 1'b1;
            else          stk_op   = STK_PUSH;
        end else if (eos_i && !ack_i && !stk_empty) begin
            stk_op = STK_POP;
        end
        // Hold the request low for one cycle after a handshake so it re-evaluates against the new level.
        st_d.req = arb_vld && !ack_i && !eos_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_req_o  = st_q.req;
    assign vec_o      = st_q.vec;
    assign overflow_o = st_q.ovf;
    assign level_o    = stk_top;
endmodule

// File: rtl/ivc_chk.sv
module ivc_chk #(
    parameter int PRIO_W = 3,
    parameter int VEC_W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ack_i,
    input logic              eos_i,
    input logic              irq_req_o,
    input logic [VEC_W-1:0]  vec_o,
    input logic [PRIO_W-1:0] level_o,
    input logic              overflow_o,
    input logic              arb_vld,
    input logic              stk_full
);
    AST_REQ_HOLDOFF: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i || eos_i) |=> !irq_req_o); // R5
    AST_LEVEL_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && arb_vld && !stk_full) |=> (level_o > $past(level_o))); // R6
    AST_VEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(ack_i && arb_vld) |=> $stable(vec_o)); // R10
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        overflow_o |=> overflow_o); // R9
    AST_EOS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (eos_i && !ack_i && level_o == '0) |=> (level_o == '0)); // R8
    AST_LEVEL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack_i && !eos_i) |=> $stable(level_o)); // R7
    AST_FULL_NO_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && arb_vld && stk_full) |=> ($stable(level_o) && overflow_o)); // R9
endmodule

bind ivc_top ivc_chk #(.PRIO_W(PRIO_W), .VEC_W(VEC_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .ack_i(ack_i), .eos_i(eos_i),
    .irq_req_o(irq_req_o), .vec_o(vec_o), .level_o(level_o),
    .overflow_o(overflow_o), .arb_vld(arb_vld), .stk_full(stk_full)
);

// File: tb/sim_ivc_top.sv
`timescale 1ns/1ps
module sim_ivc_top;
    localparam int NS = 8;
    localparam int DEP = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [NS-1:0] irq = '0;
    logic        we = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic        ack = 1'b0;
    logic        eos = 1'b0;
    logic        req;
    logic [31:0] vec;
    logic [2:0]  lvl;
    logic        ovf;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    ivc_top #(.STK_DEP(DEP)) u0 (
        .clk(clk), .rst_n(rst_n), .irq_i(irq), .cfg_we(we), .cfg_addr(addr),
        .cfg_wdata(wdata), .ack_i(ack), .eos_i(eos), .irq_req_o(req),
        .vec_o(vec), .level_o(lvl), .overflow_o(ovf)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; irq = '0; ack = 1'b0; eos = 1'b0; we = 1'b0;
        tick(); tick();
        rst_n = 1'b1;
        tick();
    endtask

    task automatic cfg(input int src, input logic [31:0] v, input logic [31:0] p);
        we = 1'b1; addr = 4'(2 * src); wdata = v; tick();
        addr = 4'(2 * src + 1); wdata = p; tick();
        we = 1'b0;
    endtask

    task automatic pulse_ack();
        ack = 1'b1; tick(); ack = 1'b0;
    endtask

    task automatic pulse_eos();
        eos = 1'b1; tick(); eos = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 req", 32'(req), 0);
        check("R1 vec", vec, 0);
        check("R1 level", 32'(lvl), 0);
        check("R1 ovf", 32'(ovf), 0);
    endtask

    task automatic t_basic();
        do_reset();
        cfg(3, 32'hA000_0003, 32'hFFFF_FFFA); // R2: low bits 010 -> priority 2
        irq[3] = 1'b1; tick();
        check("R3 req rises", 32'(req), 1);
        pulse_ack();
        check("R4 vector", vec, 32'hA000_0003);
        check("R2 priority low bits", 32'(lvl), 2);
        check("R5 req holdoff", 32'(req), 0);
        tick();
        check("R6 equal prio masked", 32'(req), 0);
        pulse_eos();
        check("R7 level pops", 32'(lvl), 0);
        check("R5 req holdoff eos", 32'(req), 0);
        tick();
        check("R7 unmasked req", 32'(req), 1);
        irq = '0;
    endtask

    task automatic t_pick();
        do_reset();
        cfg(1, 32'h11, 3);
        cfg(2, 32'h22, 5);
        cfg(5, 32'h55, 5);
        cfg(6, 32'h66, 0);
        irq[6] = 1'b1; tick(); tick();
        check("R2 disabled source", 32'(req), 0);
        irq[1] = 1'b1; irq[2] = 1'b1; irq[5] = 1'b1; tick();
        check("R3 req multi", 32'(req), 1);
        pulse_ack();
        check("R4 tie lowest index", vec, 32'h22);
        check("R5 push level", 32'(lvl), 5);
        tick();
        check("R6 lower masked", 32'(req), 0);
        irq = '0;
    endtask

    task automatic t_nest();
        do_reset();
        cfg(0, 32'hC0, 2);
        cfg(4, 32'hC4, 6);
        pulse_eos();
        check("R8 eos empty level", 32'(lvl), 0);
        check("R8 eos empty vec", vec, 0);
        pulse_ack();
        check("R10 spurious ack vec", vec, 0);
        check("R10 spurious ack level", 32'(lvl), 0);
        irq[0] = 1'b1; tick();
        pulse_ack();
        check("R5 first level", 32'(lvl), 2);
        irq[4] = 1'b1; tick(); tick();
        check("R6 preempt req", 32'(req), 1);
        pulse_ack();
        check("R6 nested vector", vec, 32'hC4);
        check("R6 nested level", 32'(lvl), 6);
        pulse_eos();
        check("R7 unwind one", 32'(lvl), 2);
        pulse_eos();
        check("R7 unwind two", 32'(lvl), 0);
        irq = '0; tick();
        pulse_eos();
        check("R8 extra eos", 32'(lvl), 0);
        check("R8 extra eos vec", vec, 32'hC4);
    endtask

    task automatic t_same_cycle();
        do_reset();
        cfg(0, 32'hD0, 2);
        cfg(4, 32'hD4, 6);
        irq[0] = 1'b1; tick();
        pulse_ack();
        irq[4] = 1'b1; tick();
        ack = 1'b1; eos = 1'b1; tick(); ack = 1'b0; eos = 1'b0;
        check("R11 ack wins level", 32'(lvl), 6);
        check("R11 ack wins vec", vec, 32'hD4);
        pulse_eos();
        check("R11 depth kept", 32'(lvl), 2);
        irq = '0;
    endtask

    task automatic t_overflow();
        do_reset();
        for (int p = 1; p <= 5; p++) cfg(p - 1, 32'h100 + 32'(p), 32'(p));
        for (int p = 1; p <= DEP; p++) begin
            irq[p-1] = 1'b1; tick();
            pulse_ack();
        end
        check("R9 full level", 32'(lvl), DEP);
        check("R9 no ovf yet", 32'(ovf), 0);
        irq[4] = 1'b1; tick();
        pulse_ack();
        check("R9 vec latched", vec, 32'h105);
        check("R9 level not pushed", 32'(lvl), DEP);
        check("R9 ovf set", 32'(ovf), 1);
        pulse_eos();
        check("R9 ovf sticky", 32'(ovf), 1);
        check("R7 pop after ovf", 32'(lvl), DEP - 1);
        irq = '0;
    endtask

    initial begin
        t_reset();
        t_basic();
        t_pick();
        t_nest();
        t_same_cycle();
        t_overflow();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(4 * 100000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule